// File: doc/BRIEF.md
# Normalizing Barrel Shifter

A 16-bit shifter for a fixed-point signal-processing datapath. Each accepted operation places the operand into a 32-bit field, either in the upper half or in the lower half, and shifts that field left or right by a signed count. The supported operations are logical shifts, arithmetic shifts, sign-exponent derivation, normalization and denormalization. Together they let software keep block floating-point values and multiword floating-point values in a common format.

A registered exponent holds the most recently derived exponent. The high-half normalize derives the exponent of its operand and applies it in the same cycle. The low-half normalize and the denormalize reuse the stored exponent, so a 32-bit mantissa can be handled one half at a time. An OR-accumulate option merges a new result into the previous one, which builds a 32-bit word from two 16-bit passes. Both outputs are registered and change only on a cycle where `valid_i` is high and `op_i` holds a defined code.

Top module: `norm_shifter`

## Requirements
- R1: While `rst_ni` is low, `result_o` and `exp_o` are both zero.
- R2: Opcode 0 (logical) places the operand zero-extended. With `hi_i`=1 the operand occupies bits 31:16 and the lower bits are zero; with `hi_i`=0 it occupies bits 15:0. A positive `shift_i` shifts left, a negative `shift_i` shifts right, and the vacated bits are filled with zeros.
- R3: Opcode 1 (arithmetic) is the same as opcode 0, except that the low placement is sign-extended and a right shift fills with bit 31 of the placed field.
- R4: A count of 32 or more gives an all-zero result. A count of -32 or less gives a result made entirely of fill bits.
- R5: Opcode 4 sets `exp_o` (two's complement) to minus the number of consecutive bits below bit 15 that equal bit 15. Operands 0x0000 and 0xFFFF therefore give -15. This opcode leaves `result_o` unchanged.
- R6: Opcode 2 with `hi_i`=1 derives the exponent of `data_i` as in R5 and writes it to `exp_o`. In the same cycle it loads `result_o` with the high-placed operand shifted left by minus that exponent, with sign fill.
- R7: Opcode 2 with `hi_i`=0 shifts the zero-extended low-placed operand left by minus the stored `exp_o`. `exp_o` is unchanged.
- R8: Opcode 3 shifts the placed operand by the stored `exp_o`, where a negative exponent shifts right. The high placement fills with the sign and the low placement is zero-extended. `exp_o` is unchanged.
- R9: With `or_i`=1, opcodes 0 to 3 load `result_o` with the bitwise OR of its previous value and the new shifted value.
- R10: Cycles with `valid_i`=0, and opcodes 5 to 7, change neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (0 logical, 1 arithmetic, 2 normalize, 3 denormalize, 4 derive exponent) |
| hi_i | input | 1 | Place operand in upper half (1) or lower half (0) |
| or_i | input | 1 | OR the new result into the previous result |
| data_i | input | 16 | Operand |
| shift_i | input | 8 | Signed shift count for opcodes 0 and 1 |
| result_o | output | 32 | Registered shifted result |
| exp_o | output | 8 | Registered signed exponent |

## Verification
The high-half normalize performs exponent derivation and shifting in one cycle. The bench drives operands whose sign runs vary in length, including 0x0000, 0xFFFF and single-bit values, and checks in that same cycle both the new `exp_o` and a `result_o` shifted by the negation of that exponent. It then runs low-half normalize and denormalize steps that must pick up exactly the exponent written by the preceding operation. Some of these steps use OR-accumulate, so the value carried from the previous cycle is checked together with the new one.

// File: rtl/norm_shift_pkg.sv
package norm_shift_pkg;
  typedef enum logic [2:0] {
    OP_LSH    = 3'd0,
    OP_ASH    = 3'd1,
    OP_NORM   = 3'd2,
    OP_DENORM = 3'd3,
    OP_EXP    = 3'd4
  } shift_op_e;
endpackage

// File: rtl/sign_exp_detect.sv
module sign_exp_detect #(
  parameter int DATA_W = 16,
  parameter int EXP_W  = 8
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [EXP_W-1:0]  exp_o
);
  logic [DATA_W-2:0] run;

  // run[i]: every bit from DATA_W-2 down to i copies the sign
  for (genvar i = DATA_W - 2; i >= 0; i--) begin : g_run
    if (i == DATA_W - 2) begin : g_top
      assign run[i] = (data_i[i] == data_i[DATA_W-1]);
    end else begin : g_rest
      assign run[i] = run[i+1] & (data_i[i] == data_i[DATA_W-1]);
    end
  end

  assign exp_o = EXP_W'(0) - EXP_W'($countones(run));
endmodule

// File: rtl/barrel_core.sv
module barrel_core #(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]     val_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             fill_i,
  output logic [W-1:0]     res_o
);
  localparam int ST    = $clog2(W);
  localparam int MAG_W = CNT_W + 1;

  logic             right;
  logic [MAG_W-1:0] mag;
  logic             big;
  logic [W-1:0]     lsh [0:ST];
  logic [W-1:0]     rsh [0:ST];

  assign right = cnt_i[CNT_W-1];
  assign mag   = right ? (MAG_W'(0) - {cnt_i[CNT_W-1], cnt_i}) : {1'b0, cnt_i};
  assign big   = |mag[MAG_W-1:ST];

  assign lsh[0] = val_i;
  assign rsh[0] = val_i;

  for (genvar s = 0; s < ST; s++) begin : g_stage
    localparam int SH = 1 << s;
    logic [2*W-1:0] r_ext;
    assign r_ext    = {{W{fill_i}}, rsh[s]} >> SH;
    assign lsh[s+1] = mag[s] ? (lsh[s] << SH) : lsh[s];
    assign rsh[s+1] = mag[s] ? r_ext[W-1:0] : rsh[s];
  end

  always_comb begin
    if (big) res_o = right ? {W{fill_i}} : '0;
    else     res_o = right ? rsh[ST] : lsh[ST];
  end
endmodule

// File: rtl/norm_shifter.sv
module norm_shifter
  import norm_shift_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [2:0]          op_i,
  input  logic                hi_i,
  input  logic                or_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [CNT_W-1:0]    shift_i,
  output logic [2*DATA_W-1:0] result_o,
  output logic [CNT_W-1:0]    exp_o
);
  localparam int RES_W = 2 * DATA_W;

  logic [RES_W-1:0] placed, shifted, res_q;
  logic [CNT_W-1:0] exp_new, exp_q, cnt;
  logic             fill, sext, res_we, exp_we;

  sign_exp_detect #(.DATA_W(DATA_W), .EXP_W(CNT_W)) u_exp (
    .data_i (data_i),
    .exp_o  (exp_new)
  );

  assign sext = (op_i == OP_ASH);

  always_comb begin
    if (hi_i)      placed = {data_i, {DATA_W{1'b0}}};
    else if (sext) placed = {{DATA_W{data_i[DATA_W-1]}}, data_i};
    else           placed = {{DATA_W{1'b0}}, data_i};
  end

  assign fill = (op_i != OP_LSH) & placed[RES_W-1];

  always_comb begin
    case (op_i)
      OP_NORM:   cnt = hi_i ? (CNT_W'(0) - exp_new) : (CNT_W'(0) - exp_q);
      OP_DENORM: cnt = exp_q;
      default:   cnt = shift_i;
    endcase
  end

  barrel_core #(.W(RES_W), .CNT_W(CNT_W)) u_core (
    .val_i  (placed),
    .cnt_i  (cnt),
    .fill_i (fill),
    .res_o  (shifted)
  );

  assign res_we = valid_i & (op_i <= OP_DENORM);
  assign exp_we = valid_i & ((op_i == OP_EXP) | ((op_i == OP_NORM) & hi_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      exp_q <= '0;
    end else begin
      if (res_we) res_q <= or_i ? (res_q | shifted) : shifted;
      if (exp_we) exp_q <= exp_new;
    end
  end

  assign result_o = res_q;
  assign exp_o    = exp_q;
endmodule

// File: rtl/norm_shifter_chk.sv
module norm_shifter_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [2:0]          op_i,
  input logic                hi_i,
  input logic                or_i,
  input logic [DATA_W-1:0]   data_i,
  input logic [2*DATA_W-1:0] result_o,
  input logic [CNT_W-1:0]    exp_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |=> (result_o == '0 && exp_o == '0)); // R1

  AST_EXP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(exp_o) <= 0 && $signed(exp_o) >= -(DATA_W - 1))); // R5

  AST_EXP_KEEPS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=> $stable(result_o)); // R5

  AST_NORM_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && hi_i && !or_i && data_i != '0)
    |=> (result_o[2*DATA_W-1] != result_o[2*DATA_W-2])); // R6

  AST_EXP_STABLE_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ((op_i == 3'd2 && !hi_i) || op_i == 3'd3)) |=> $stable(exp_o)); // R7

  AST_OR_KEEPS_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && or_i && op_i <= 3'd3) |=> ((result_o & $past(result_o)) == $past(result_o))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || op_i > 3'd4) |=> ($stable(result_o) && $stable(exp_o))); // R10
endmodule

bind norm_shifter norm_shifter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .hi_i     (hi_i),
  .or_i     (or_i),
  .data_i   (data_i),
  .result_o (result_o),
  .exp_o    (exp_o)
);

// File: tb/sim_norm_shifter.sv
`timescale 1ns/1ps
module sim_norm_shifter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic        hi_i = 1'b0;
  logic        or_i = 1'b0;
  logic [15:0] data_i = 16'h0;
  logic [7:0]  shift_i = 8'h0;
  logic [31:0] result_o;
  logic [7:0]  exp_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] m_res = 32'h0;
  int          m_exp = 0;

  always #5 clk = ~clk;

  norm_shifter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .hi_i(hi_i),
    .or_i(or_i), .data_i(data_i), .shift_i(shift_i), .result_o(result_o), .exp_o(exp_o)
  );

  function automatic int ref_exp(input logic [15:0] d);
    int n = 0;
    for (int i = 14; i >= 0; i--) begin
      if (d[i] != d[15]) break;
      n++;
    end
    return -n;
  endfunction

  function automatic logic [31:0] ref_shift(input int op, input bit hi, input logic [15:0] d, input int cnt);
    logic [31:0] p;
    bit f;
    if (hi)           p = {d, 16'h0};
    else if (op == 1) p = {{16{d[15]}}, d};
    else              p = {16'h0, d};
    f = (op != 0) && p[31];
    if (cnt >= 0) return (cnt >= 32) ? 32'h0 : (p << cnt);
    if (-cnt >= 32) return {32{f}};
    if (f) return 32'($signed(p) >>> (-cnt));
    return p >> (-cnt);
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input string req, input bit v, input int op, input bit hi, input bit orr,
                     input logic [15:0] d, input int cnt);
    logic [31:0] nv;
    bit wr = 1'b0;
    @(negedge clk);
    valid_i = v; op_i = op[2:0]; hi_i = hi; or_i = orr; data_i = d; shift_i = cnt[7:0];
    if (v) begin
      case (op)
        0, 1: begin nv = ref_shift(op, hi, d, cnt); wr = 1'b1; end
        2: begin
          if (hi) begin m_exp = ref_exp(d); nv = ref_shift(2, 1'b1, d, -m_exp); end
          else nv = ref_shift(2, 1'b0, d, -m_exp);
          wr = 1'b1;
        end
        3: begin nv = ref_shift(3, hi, d, m_exp); wr = 1'b1; end
        4: m_exp = ref_exp(d);
        default: ;
      endcase
      if (wr) m_res = orr ? (m_res | nv) : nv;
    end
    @(negedge clk);
    valid_i = 1'b0;
    check(req, "result", longint'(result_o), longint'(m_res));
    check(req, "exp", longint'($signed(exp_o)), longint'(m_exp));
  endtask

  task automatic t_reset();
    #3;
    check("R1", "result", longint'(result_o), 0);
    check("R1", "exp", longint'(exp_o), 0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_logical();
    run("R2", 1, 0, 1, 0, 16'h8001, 0);
    run("R2", 1, 0, 1, 0, 16'h8001, -4);
    run("R2", 1, 0, 0, 0, 16'h8001, 4);
    run("R2", 1, 0, 0, 0, 16'hF00F, 17);
    run("R2", 1, 0, 1, 0, 16'hC3A5, -31);
  endtask

  task automatic t_arith();
    run("R3", 1, 1, 0, 0, 16'h8001, -4);
    run("R3", 1, 1, 1, 0, 16'h9234, -7);
    run("R3", 1, 1, 0, 0, 16'h7FFF, -3);
    run("R3", 1, 1, 0, 0, 16'h8000, 5);
  endtask

  task automatic t_range();
    run("R4", 1, 0, 0, 0, 16'hFFFF, 32);
    run("R4", 1, 1, 1, 0, 16'h8000, -32);
    run("R4", 1, 1, 1, 0, 16'h7000, -128);
    run("R4", 1, 0, 1, 0, 16'hFFFF, -40);
    run("R4", 1, 1, 0, 0, 16'h1234, 127);
  endtask

  task automatic t_exp();
    run("R2", 1, 0, 1, 0, 16'hABCD, 0);
    run("R5", 1, 4, 0, 0, 16'h0000, 0);
    run("R5", 1, 4, 0, 0, 16'hFFFF, 0);
    run("R5", 1, 4, 0, 0, 16'h4000, 0);
    run("R5", 1, 4, 1, 0, 16'h0001, 0);
    run("R5", 1, 4, 0, 0, 16'hF800, 0);
  endtask

  task automatic t_norm();
    run("R6", 1, 2, 1, 0, 16'h0001, 0);
    run("R6", 1, 2, 1, 0, 16'hFFFF, 0);
    run("R6", 1, 2, 1, 0, 16'h0000, 0);
    run("R6", 1, 2, 1, 0, 16'hFC12, 0);
    run("R7", 1, 2, 0, 1, 16'hBEEF, 0);
    run("R6", 1, 2, 1, 0, 16'h0033, 0);
    run("R7", 1, 2, 0, 1, 16'h8421, 0);
  endtask

  task automatic t_denorm();
    run("R5", 1, 4, 0, 0, 16'h0010, 0);
    run("R8", 1, 3, 1, 0, 16'h8F00, 0);
    run("R8", 1, 3, 0, 1, 16'h8F00, 0);
    run("R5", 1, 4, 0, 0, 16'h4000, 0);
    run("R8", 1, 3, 1, 0, 16'hA5A5, 0);
  endtask

  task automatic t_or();
    run("R9", 1, 0, 1, 0, 16'h1234, 0);
    run("R9", 1, 0, 0, 1, 16'h5678, 0);
    run("R9", 1, 1, 0, 1, 16'h0F00, -4);
  endtask

  task automatic t_hold();
    run("R10", 0, 0, 0, 0, 16'hFFFF, 3);
    run("R10", 0, 4, 0, 0, 16'h0001, 0);
    run("R10", 1, 5, 1, 0, 16'h8000, 0);
    run("R10", 1, 7, 0, 1, 16'hFFFF, 2);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    t_reset();
    t_logical();
    t_arith();
    t_range();
    t_exp();
    t_norm();
    t_denorm();
    t_or();
    t_hold();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule